// File: doc/BRIEF.md
# SPI Framed Register Interface

This block is an SPI peripheral that gives a host access to a small 8-bit register file. Each transaction is one 16-bit frame, bounded by one assertion of the active-low chip select. The upper byte of a frame carries a write flag (bit 15) and a 7-bit register address (bits 14:8). The lower byte carries the data to store or, for reads, a view selector. The block runs on its own system clock and oversamples SCK, chip select and MOSI through two-flop synchronizers. SCK can therefore run up to a tenth of the system clock rate.

Reads are pipelined by one frame. The frame that asks for a register does not carry its contents. The reply is shifted out on MISO during the next frame, in bits 13:0 with bits 15:14 at zero. A read can use one of two views. The control view returns the stored byte. The status view returns a 14-bit word taken from the `sts_in` port. The whole register file is presented in flat form on `reg_q` for the downstream datapath.

A frame controller steps through three states. IDLE waits for chip select to fall. On that edge it loads the pending reply into the transmit shifter, clears the bit counter and moves to XFER. XFER shifts MOSI in on each SCK falling edge and MISO out on each SCK rising edge. When chip select rises it moves to DONE. DONE commits the frame if exactly sixteen falling edges were counted, then always returns to IDLE.

Top module: `spi_frm_regif`

## Requirements
- R1: The interface uses SPI mode 1 (CPOL=0, CPHA=1). MOSI is sampled on SCK falling edges, MSB first, while `spi_cs_n` is low. Frame bit 15 is the write flag, bits 14:8 are the address and bits 7:0 are the data byte.
- R2: A write frame (bit 15 = 1) to a mapped address (address < NUM_REGS, default 32) stores the data byte when chip select rises. The byte appears on `reg_q[addr*8 +: 8]`.
- R3: A frame with any number of SCK falling edges other than 16 is discarded. No register changes, and the pending reply stays unchanged, so the next full frame returns it.
- R4: A read frame (bit 15 = 0) with data bit 7 = 1 selects the control view. The next frame shifts out {2'b00, 6'b0, register byte}.
- R5: A read frame with data bit 7 = 0 selects the status view. The next frame shifts out {2'b00, sts_in}, with `sts_in` sampled when the read frame ends.
- R6: Addresses at or above NUM_REGS are unmapped. Writes to them change nothing, and control-view reads of them return zero.
- R7: The frame that follows a write frame shifts out all zeros.
- R8: MISO presents the reply MSB first and changes only after an SCK rising edge. After reset the register file is zero, MISO is low and the first reply is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | SPI serial clock, idle low |
| spi_cs_n | input | 1 | Active-low chip select, one frame per assertion |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial reply to the host |
| sts_in | input | 14 | Status word returned by status-view reads |
| reg_q | output | NUM_REGS*8 | Flat register file contents, register n in bits n*8+7:n*8 |

## Verification
Two things can happen at the same frame boundary. The reply to a read is leaving the transmit shifter, and the next frame's write is being committed to that same register. To provoke this, the bench reads an address and then, in the very next frame, writes a new value to it. The reply shifted out during the write frame must still be the old byte. `reg_q` must show the new byte once chip select rises. The frame after that must return zero.

Pipelining must also survive a discarded frame. The bench checks this with frames of 15 and 17 clocks placed between a read and its reply.

// File: rtl/spi_frm_pkg.sv
package spi_frm_pkg;
    localparam int FRAME_BITS = 16;
    localparam int CNT_W      = 5;
    localparam int ADDR_W     = 7;
    localparam int DATA_W     = 8;
    localparam int PAY_W      = 14;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_DONE = 2'd2
    } frm_state_t;
endpackage

// File: rtl/spi_frm_sync.sv
module spi_frm_sync #(
    parameter int           W       = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q_out
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic meta_q, stab_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= RST_VAL[g];
                stab_q <= RST_VAL[g];
            end else begin
                meta_q <= d_in[g];
                stab_q <= meta_q;
            end
        end
        assign q_out[g] = stab_q;
    end
endmodule

// File: rtl/spi_frm_shift.sv
module spi_frm_shift
    import spi_frm_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic [FRAME_BITS-1:0] load_word,
    input  logic                  active,
    input  logic                  sck_rise,
    input  logic                  sck_fall,
    input  logic                  mosi_in,
    output logic [FRAME_BITS-1:0] rx_word,
    output logic [CNT_W-1:0]      bit_cnt,
    output logic                  miso
);
    logic [FRAME_BITS-1:0] tx_sr;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sr   <= '0;
            rx_word <= '0;
            bit_cnt <= '0;
            miso    <= 1'b0;
        end else if (load) begin
            tx_sr   <= load_word;
            bit_cnt <= '0;
        end else if (active) begin
            if (sck_fall) begin
                rx_word <= {rx_word[FRAME_BITS-2:0], mosi_in};
                if (bit_cnt != CNT_MAX)
                    bit_cnt <= bit_cnt + 1'b1;
            end
            if (sck_rise) begin
                miso  <= tx_sr[FRAME_BITS-1];
                tx_sr <= {tx_sr[FRAME_BITS-2:0], 1'b0};
            end
        end
    end
endmodule

// File: rtl/spi_frm_regs.sv
module spi_frm_regs
    import spi_frm_pkg::*;
#(
    parameter int NUM_REGS = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [DATA_W-1:0]        rd_data,
    output logic [NUM_REGS*DATA_W-1:0] reg_q
);
    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
    localparam logic [ADDR_W:0] NUM_L = NUM_REGS[ADDR_W:0];

    logic [DATA_W-1:0] mem [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        localparam logic [ADDR_W-1:0] GA = ADDR_W'(g);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                mem[g] <= '0;
            else if (wr_en && wr_addr == GA)
                mem[g] <= wr_data;
        end
        assign reg_q[g*DATA_W +: DATA_W] = mem[g];
    end

    always_comb begin
        rd_data = '0;
        if ({1'b0, rd_addr} < NUM_L)
            rd_data = mem[rd_addr[IDX_W-1:0]];
    end
endmodule

// File: rtl/spi_frm_regif.sv
module spi_frm_regif
    import spi_frm_pkg::*;
#(
    parameter int NUM_REGS = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         spi_sck,
    input  logic                         spi_cs_n,
    input  logic                         spi_mosi,
    output logic                         spi_miso,
    input  logic [PAY_W-1:0]             sts_in,
    output logic [NUM_REGS*DATA_W-1:0]   reg_q
);
    localparam logic [ADDR_W:0]  NUM_L   = NUM_REGS[ADDR_W:0];
    localparam logic [CNT_W-1:0] FULL_CT = CNT_W'(FRAME_BITS);

    logic [2:0] sync_q;
    logic       s_cs, s_sck, s_mosi, d_cs, d_sck;
    logic       sck_rise, sck_fall, cs_fall, cs_rise;

    spi_frm_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d_in({spi_cs_n, spi_sck, spi_mosi}), .q_out(sync_q)
    );
    assign {s_cs, s_sck, s_mosi} = sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            d_cs  <= 1'b1;
            d_sck <= 1'b0;
        end else begin
            d_cs  <= s_cs;
            d_sck <= s_sck;
        end
    end
    assign sck_rise = s_sck & ~d_sck;
    assign sck_fall = ~s_sck & d_sck;
    assign cs_fall  = ~s_cs & d_cs;
    assign cs_rise  = s_cs & ~d_cs;

    frm_state_t state, nxt_state;
    logic [FRAME_BITS-1:0] rx_word, resp_q;
    logic [CNT_W-1:0]      bit_cnt;
    logic                  load, active, commit, wr_en;
    logic [ADDR_W-1:0]     frm_addr;
    logic [DATA_W-1:0]     frm_data, rd_data;
    logic                  frm_wr;

    assign frm_wr   = rx_word[FRAME_BITS-1];
    assign frm_addr = rx_word[FRAME_BITS-2 -: ADDR_W];
    assign frm_data = rx_word[DATA_W-1:0];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt_state;
    end

    always_comb begin
        nxt_state = state;
        unique case (state)
            ST_IDLE: if (cs_fall) nxt_state = ST_XFER;
            ST_XFER: if (cs_rise) nxt_state = ST_DONE;
            ST_DONE: nxt_state = ST_IDLE;
            default: nxt_state = ST_IDLE;
        endcase
    end

    // Outputs of the frame controller
    always_comb begin
        load   = 1'b0;
        active = 1'b0;
        commit = 1'b0;
        unique case (state)
            ST_IDLE: load   = cs_fall;
            ST_XFER: active = 1'b1;
            ST_DONE: commit = (bit_cnt == FULL_CT);
            default: ;
        endcase
        wr_en = commit && frm_wr && ({1'b0, frm_addr} < NUM_L);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            resp_q <= '0;
        else if (commit) begin
            if (frm_wr)
                resp_q <= '0;
            else if (frm_data[DATA_W-1])
                resp_q <= {{(FRAME_BITS-DATA_W){1'b0}}, rd_data};
            else
                resp_q <= {{(FRAME_BITS-PAY_W){1'b0}}, sts_in};
        end
    end

    spi_frm_shift u_shift (
        .clk(clk), .rst_n(rst_n), .load(load), .load_word(resp_q),
        .active(active), .sck_rise(sck_rise), .sck_fall(sck_fall),
        .mosi_in(s_mosi), .rx_word(rx_word), .bit_cnt(bit_cnt),
        .miso(spi_miso)
    );

    spi_frm_regs #(.NUM_REGS(NUM_REGS)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(frm_addr),
        .wr_data(frm_data), .rd_addr(frm_addr), .rd_data(rd_data),
        .reg_q(reg_q)
    );
endmodule

// File: rtl/spi_frm_regif_chk.sv
module spi_frm_regif_chk
    import spi_frm_pkg::*;
#(
    parameter int NUM_REGS = 32
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       wr_en,
    input logic                       sck_rise,
    input logic                       cs_fall,
    input logic                       commit,
    input logic [CNT_W-1:0]           bit_cnt,
    input logic [FRAME_BITS-1:0]      resp_q,
    input logic [NUM_REGS*DATA_W-1:0] reg_q,
    input logic                       spi_miso
);
    // R2 / R6: register file moves only on a committed write
    p_reg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(reg_q));

    // R8: MISO changes only after a detected SCK rising edge
    p_miso_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !sck_rise |=> $stable(spi_miso));

    // R1: each frame starts counting from zero
    p_cnt_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_fall |=> (bit_cnt == '0));

    // R3: pending reply is only replaced by a completed frame
    p_resp_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(resp_q));

    // R7: reply field never exceeds the 14-bit payload
    p_resp_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (resp_q[FRAME_BITS-1 -: 2] == 2'b00));
endmodule

bind spi_frm_regif spi_frm_regif_chk #(.NUM_REGS(NUM_REGS)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .sck_rise(sck_rise),
    .cs_fall(cs_fall), .commit(commit), .bit_cnt(bit_cnt),
    .resp_q(resp_q), .reg_q(reg_q), .spi_miso(spi_miso)
);

// File: tb/tb_spi_frm_regif.sv
module tb_spi_frm_regif;
    localparam int NREG = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spi_sck = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
    logic spi_miso;
    logic [13:0] sts_in = '0;
    logic [NREG*8-1:0] reg_q;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    logic [7:0]  exp_reg [NREG];
    logic [15:0] pend;
    string       pend_req;

    always #5 clk = ~clk;

    spi_frm_regif #(.NUM_REGS(NREG)) dut (
        .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .sts_in(sts_in), .reg_q(reg_q)
    );

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [NREG*8-1:0] exp_flat();
        logic [NREG*8-1:0] f;
        for (int i = 0; i < NREG; i++) f[i*8 +: 8] = exp_reg[i];
        return f;
    endfunction

    task automatic xfer(input logic [15:0] tx, input int nclk, output logic [15:0] rx);
        rx = '0;
        spi_cs_n = 1'b0;
        wclk(6);
        for (int i = 0; i < nclk; i++) begin
            spi_sck  = 1'b1;
            spi_mosi = (i < 16) ? tx[15-i] : 1'b0;
            wclk(6);
            rx = {rx[14:0], spi_miso};
            spi_sck = 1'b0;
            wclk(6);
        end
        spi_cs_n = 1'b1;
        wclk(8);
    endtask

    // Full 16-clock frame: check reply against model, then update the model
    task automatic frame(input logic [15:0] tx);
        logic [15:0] rx;
        logic [6:0]  a;
        xfer(tx, 16, rx);
        chk(pend_req, {240'b0, rx}, {240'b0, pend});
        a = tx[14:8];
        if (tx[15]) begin
            if (a < NREG) exp_reg[a] = tx[7:0];
            pend = '0; pend_req = "R7";
        end else if (tx[7]) begin
            pend = (a < NREG) ? {8'h00, exp_reg[a]} : 16'h0;
            pend_req = (a < NREG) ? "R4" : "R6";
        end else begin
            pend = {2'b00, sts_in}; pend_req = "R5";
        end
    endtask

    initial begin
        wclk(200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] rx;
        for (int i = 0; i < NREG; i++) exp_reg[i] = '0;
        pend = '0; pend_req = "R8";
        wclk(4);
        rst_n = 1'b1;
        wclk(4);
        // R8: reset state
        chk("R8", {255'b0, spi_miso}, 256'b0);
        chk("R8", {{(256-NREG*8){1'b0}}, reg_q}, 256'b0);
        frame(16'h0080);   // first reply zero (R8)

        // R1/R2/R6: write sweep over all 128 addresses
        for (int a = 0; a < 128; a++) begin
            frame({1'b1, 7'(a), 8'((a * 37 + 11) & 8'hFF)});
            chk(a < NREG ? "R2" : "R6", {{(256-NREG*8){1'b0}}, reg_q},
                {{(256-NREG*8){1'b0}}, exp_flat()});
        end
        // R4/R6: control-view read sweep, pipelined replies
        for (int a = 0; a < 128; a++) frame({1'b0, 7'(a), 8'h80});
        // R5: status view
        sts_in = 14'h2A5C;
        frame(16'h0300);
        sts_in = 14'h1001;
        frame(16'h0080);
        frame(16'h0200);
        frame(16'h0580);

        // R3: short and long frames discarded, pending reply retained
        xfer(16'h8399, 15, rx);
        chk("R3", {{(256-NREG*8){1'b0}}, reg_q}, {{(256-NREG*8){1'b0}}, exp_flat()});
        xfer(16'h8377, 17, rx);
        chk("R3", {{(256-NREG*8){1'b0}}, reg_q}, {{(256-NREG*8){1'b0}}, exp_flat()});
        frame(16'h0080);   // still returns address 5 reply (R3)

        // Read then immediate write of the same register
        frame(16'h0780);
        frame(16'h87C3);   // reply = old value (R4), write commits (R2)
        chk("R2", {248'b0, reg_q[7*8 +: 8]}, {248'b0, 8'hC3});
        frame(16'h0780);   // reply zero after write (R7)
        frame(16'h0000);   // reply new value (R4)

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule